// File: doc/BRIEF.md
# PC Card Host Access Decoder

This block sits behind a 16-bit PC Card style slot and turns host cycles into accesses on an 8-bit internal bus. Every slot cycle is sorted into common memory, attribute memory or I/O space, read or write, and even or odd byte. The sort uses card enable, the attribute select, the memory output and write enables, and the two I/O strobes. A recognised cycle produces exactly one internal read or write strobe, together with the byte address and a space code. The block holds the host cycle with an active-low wait output until the internal target returns ready.

A single configuration option byte lives at a fixed attribute address. While its index field is zero the card is memory-only, so I/O strobes are ignored and the input-acknowledge output stays inactive. Writing a nonzero index enables I/O decode within a small I/O window. Reset clears the byte and returns the card to memory-only operation. Read data goes back to the slot through a data output with its own drive enable. The enable is raised only while the card is enabled, the read strobe that matches the cycle is low, and the data is valid.

All slot inputs are captured in a register stage before decode. All outputs are registered. Results therefore appear two clock edges after a slot input changes.

Top module: `pccard_host_decoder`

## Requirements
- R1: While card_en_n is high, no internal strobe is issued, host_rdata_oe stays 0 and inpack_n stays 1, whatever the other slot inputs are.
- R2: With reg_sel_n high and card_en_n low, oe_n low with we_n high is a common memory read, and we_n low with oe_n high is a common memory write. Both need iord_n and iowr_n high, and both use space code 2'b00 on int_space. Any other combination (for example oe_n and we_n both low) issues nothing.
- R3: With reg_sel_n low and both I/O strobes high, the same oe_n/we_n rules select an attribute memory read or write, with space code 2'b01.
- R4: int_addr carries the full host byte address. Its bit 0 equals host_addr[0], so an even address picks the even byte and an odd address picks the odd byte of the 8-bit path.
- R5: With reg_sel_n low and oe_n, we_n high, iord_n low is an I/O read and iowr_n low is an I/O write, with space code 2'b10. The block accepts them only while cfg_io_en is 1 and host_addr is below 2**IO_AW (16 by default). Otherwise they are ignored.
- R6: inpack_n is low only while an accepted I/O read is in progress. It is never low while the card is unconfigured.
- R7: An active-high synchronous rst clears the option byte, drops cfg_io_en to 0 and leaves wait_n=1, inpack_n=1, host_rdata_oe=0 and no strobe.
- R8: The option byte sits at attribute address CFG_ADDR (default 12'h200). An attribute write there stores host_wdata, and an attribute read returns it. Neither reaches the internal bus or asserts wait_n. cfg_io_en is 1 exactly when the low 6 bits of the byte are nonzero.
- R9: host_rdata_oe is 1 only while card_en_n is low, the read strobe that matches the cycle (oe_n for memory, iord_n for I/O) is low, and the read data has been returned. It goes back to 0 after that strobe is released.
- R10: wait_n goes low in the same cycle as the internal strobe. It stays low until int_ready is seen, and goes high one clock after that.
- R11: Each host access yields exactly one single-cycle int_rd or int_wr pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_en_n | input | 1 | Card enable, active low |
| reg_sel_n | input | 1 | Attribute/I-O select, active low |
| oe_n | input | 1 | Memory output enable, active low |
| we_n | input | 1 | Memory write enable, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| host_addr | input | AW | Host byte address |
| host_wdata | input | DW | Write data from the slot |
| host_rdata | output | DW | Read data toward the slot |
| host_rdata_oe | output | 1 | Drive enable for host_rdata |
| inpack_n | output | 1 | I/O read acknowledge, active low |
| wait_n | output | 1 | Cycle extend, active low |
| int_rd | output | 1 | Internal read strobe (one cycle) |
| int_wr | output | 1 | Internal write strobe (one cycle) |
| int_space | output | 2 | Space code of the strobed access |
| int_addr | output | AW | Internal byte address |
| int_wdata | output | DW | Internal write data |
| int_rdata | input | DW | Internal read data, valid with int_ready |
| int_ready | input | 1 | Internal target completion |
| cfg_io_en | output | 1 | Card configured for I/O |

## Verification
The assertions assume that a host cycle keeps its control and address inputs steady from assertion until its strobe is released. They also assume an idle gap of at least two clocks with all strobes high separates two accesses, and that the internal target raises int_ready only for a strobe it has received. The stimulus follows these rules: it drives each cycle at a falling clock edge, holds it until wait_n returns high, then idles for several clocks. The internal target model answers each strobe once, after a latency that the bench varies from zero to several clocks.

// File: rtl/pcc_dec_pkg.sv
package pcc_dec_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CM_RD,
    ACC_CM_WR,
    ACC_AM_RD,
    ACC_AM_WR,
    ACC_IO_RD,
    ACC_IO_WR
  } acc_kind_t;

  localparam logic [1:0] SPACE_COMMON = 2'b00;
  localparam logic [1:0] SPACE_ATTR   = 2'b01;
  localparam logic [1:0] SPACE_IO     = 2'b10;

  typedef struct packed {
    logic ce_n;
    logic reg_n;
    logic oe_n;
    logic we_n;
    logic iord_n;
    logic iowr_n;
  } slot_ctl_t;

  function automatic logic kind_is_read(acc_kind_t k);
    return (k == ACC_CM_RD) || (k == ACC_AM_RD) || (k == ACC_IO_RD);
  endfunction

  function automatic logic kind_is_write(acc_kind_t k);
    return (k == ACC_CM_WR) || (k == ACC_AM_WR) || (k == ACC_IO_WR);
  endfunction

  function automatic logic [1:0] space_of(acc_kind_t k);
    case (k)
      ACC_AM_RD, ACC_AM_WR: return SPACE_ATTR;
      ACC_IO_RD, ACC_IO_WR: return SPACE_IO;
      default:              return SPACE_COMMON;
    endcase
  endfunction

endpackage

// File: rtl/pcc_slot_sampler.sv
module pcc_slot_sampler
  import pcc_dec_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  slot_ctl_t     ctl_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output slot_ctl_t     ctl_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '1;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ctl_q   <= ctl_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

endmodule

// File: rtl/pcc_cycle_decode.sv
module pcc_cycle_decode
  import pcc_dec_pkg::*;
#(
  parameter int AW       = 12,
  parameter int IO_AW    = 4,
  parameter int CFG_ADDR = 'h200
) (
  input  slot_ctl_t     ctl,
  input  logic [AW-1:0] addr,
  input  logic          io_en,
  output acc_kind_t     kind,
  output logic          cfg_hit
);

  localparam logic [AW-1:0] CFG_A = AW'(CFG_ADDR);

  logic io_hit;
  logic mem_rd, mem_wr, io_rd, io_wr, io_idle, mem_idle;

  generate
    if (IO_AW >= AW) begin : g_io_full
      assign io_hit = 1'b1;
    end else begin : g_io_window
      assign io_hit = (addr[AW-1:IO_AW] == '0);
    end
  endgenerate

  assign io_idle  = ctl.iord_n & ctl.iowr_n;
  assign mem_idle = ctl.oe_n & ctl.we_n;
  assign mem_rd   = io_idle & ~ctl.oe_n & ctl.we_n;
  assign mem_wr   = io_idle & ctl.oe_n & ~ctl.we_n;
  assign io_rd    = mem_idle & ~ctl.iord_n & ctl.iowr_n;
  assign io_wr    = mem_idle & ctl.iord_n & ~ctl.iowr_n;

  always_comb begin
    kind = ACC_NONE;
    if (!ctl.ce_n) begin
      if (ctl.reg_n) begin
        if (mem_rd)      kind = ACC_CM_RD;
        else if (mem_wr) kind = ACC_CM_WR;
      end else begin
        if (mem_rd)                        kind = ACC_AM_RD;
        else if (mem_wr)                   kind = ACC_AM_WR;
        else if (io_rd && io_en && io_hit) kind = ACC_IO_RD;
        else if (io_wr && io_en && io_hit) kind = ACC_IO_WR;
      end
    end
  end

  assign cfg_hit = ((kind == ACC_AM_RD) || (kind == ACC_AM_WR)) && (addr == CFG_A);

endmodule

// File: rtl/pcc_cfg_reg.sv
module pcc_cfg_reg #(
  parameter int DW    = 8,
  parameter int IDX_W = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] opt_q,
  output logic          io_en
);

  always_ff @(posedge clk) begin
    if (rst)        opt_q <= '0;
    else if (wr_en) opt_q <= wdata;
  end

  assign io_en = |opt_q[IDX_W-1:0];

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(opt_q)) else $error("option byte changed without write"); // R8

endmodule

// File: rtl/pcc_access_fsm.sv
module pcc_access_fsm
  import pcc_dec_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  acc_kind_t     kind,
  input  logic          cfg_hit,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] opt_val,
  input  logic          int_ready,
  input  logic [DW-1:0] int_rdata,
  output logic          cfg_wr,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [1:0]    space,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          wait_n,
  output logic          data_oe,
  output logic [DW-1:0] data_out,
  output logic          inpack_n
);

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_HOLD} st_t;

  st_t           st_q, st_n;
  logic          valid_q, valid_n;
  logic          rdacc_q, rdacc_n;
  logic [DW-1:0] rdata_q, rdata_n;
  logic          rd_n, wr_n, wait_q, wait_nx;
  logic [1:0]    space_q, space_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] wdata_q, wdata_n;
  logic          oe_q, inpack_q;

  assign cfg_wr = (st_q == ST_IDLE) && (kind == ACC_AM_WR) && cfg_hit;

  always_comb begin
    st_n    = st_q;
    valid_n = valid_q;
    rdacc_n = rdacc_q;
    rdata_n = rdata_q;
    rd_n    = 1'b0;
    wr_n    = 1'b0;
    wait_nx = wait_q;
    space_n = space_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    case (st_q)
      ST_IDLE: begin
        valid_n = 1'b0;
        if (kind != ACC_NONE) begin
          if (cfg_hit) begin
            st_n = ST_HOLD;
            if (kind_is_read(kind)) begin
              rdata_n = opt_val;
              valid_n = 1'b1;
            end
          end else begin
            rd_n    = kind_is_read(kind);
            wr_n    = kind_is_write(kind);
            rdacc_n = kind_is_read(kind);
            space_n = space_of(kind);
            addr_n  = addr;
            wdata_n = wdata;
            wait_nx = 1'b0;
            st_n    = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (kind == ACC_NONE) begin
          wait_nx = 1'b1;
          st_n    = ST_IDLE;
        end else if (int_ready) begin
          wait_nx = 1'b1;
          st_n    = ST_HOLD;
          if (rdacc_q) begin
            rdata_n = int_rdata;
            valid_n = 1'b1;
          end
        end
      end
      default: begin
        if (kind == ACC_NONE) begin
          st_n    = ST_IDLE;
          valid_n = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      valid_q  <= 1'b0;
      rdacc_q  <= 1'b0;
      rdata_q  <= '0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      wait_q   <= 1'b1;
      space_q  <= SPACE_COMMON;
      addr_q   <= '0;
      wdata_q  <= '0;
      oe_q     <= 1'b0;
      inpack_q <= 1'b1;
    end else begin
      st_q     <= st_n;
      valid_q  <= valid_n;
      rdacc_q  <= rdacc_n;
      rdata_q  <= rdata_n;
      rd_stb   <= rd_n;
      wr_stb   <= wr_n;
      wait_q   <= wait_nx;
      space_q  <= space_n;
      addr_q   <= addr_n;
      wdata_q  <= wdata_n;
      oe_q     <= valid_n && kind_is_read(kind);
      inpack_q <= !(kind == ACC_IO_RD);
    end
  end

  assign space    = space_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign wait_n   = wait_q;
  assign data_oe  = oe_q;
  assign data_out = rdata_q;
  assign inpack_n = inpack_q;

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb) |=> !(rd_stb || wr_stb)) else $error("strobe longer than one cycle"); // R11
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_stb, wr_stb})) else $error("read and write strobes together"); // R11
  AST_WAIT_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb) |-> !wait_n) else $error("strobe without wait"); // R10
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!wait_n && int_ready) |=> wait_n) else $error("wait not released after ready"); // R10

endmodule

// File: rtl/pccard_host_decoder.sv
module pccard_host_decoder
  import pcc_dec_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 8,
  parameter int IO_AW    = 4,
  parameter int IDX_W    = 6,
  parameter int CFG_ADDR = 'h200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          card_en_n,
  input  logic          reg_sel_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          iord_n,
  input  logic          iowr_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdata_oe,
  output logic          inpack_n,
  output logic          wait_n,
  output logic          int_rd,
  output logic          int_wr,
  output logic [1:0]    int_space,
  output logic [AW-1:0] int_addr,
  output logic [DW-1:0] int_wdata,
  input  logic [DW-1:0] int_rdata,
  input  logic          int_ready,
  output logic          cfg_io_en
);

  slot_ctl_t     ctl_in, s_ctl;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  acc_kind_t     kind;
  logic          cfg_hit, cfg_wr;
  logic [DW-1:0] opt_val;

  assign ctl_in = '{ce_n: card_en_n, reg_n: reg_sel_n, oe_n: oe_n, we_n: we_n,
                    iord_n: iord_n, iowr_n: iowr_n};

  pcc_slot_sampler #(.AW(AW), .DW(DW)) u_sampler (
    .clk(clk), .rst(rst), .ctl_in(ctl_in), .addr_in(host_addr), .wdata_in(host_wdata),
    .ctl_q(s_ctl), .addr_q(s_addr), .wdata_q(s_wdata)
  );

  pcc_cycle_decode #(.AW(AW), .IO_AW(IO_AW), .CFG_ADDR(CFG_ADDR)) u_decode (
    .ctl(s_ctl), .addr(s_addr), .io_en(cfg_io_en), .kind(kind), .cfg_hit(cfg_hit)
  );

  pcc_cfg_reg #(.DW(DW), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wdata(s_wdata), .opt_q(opt_val), .io_en(cfg_io_en)
  );

  pcc_access_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .kind(kind), .cfg_hit(cfg_hit), .addr(s_addr), .wdata(s_wdata),
    .opt_val(opt_val), .int_ready(int_ready), .int_rdata(int_rdata), .cfg_wr(cfg_wr),
    .rd_stb(int_rd), .wr_stb(int_wr), .space(int_space), .addr_o(int_addr),
    .wdata_o(int_wdata), .wait_n(wait_n), .data_oe(host_rdata_oe), .data_out(host_rdata),
    .inpack_n(inpack_n)
  );

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    s_ctl.ce_n |=> !(int_rd || int_wr)) else $error("strobe while card disabled"); // R1
  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    host_rdata_oe |-> ($past(s_ctl.ce_n) == 1'b0)) else $error("data driven without card enable"); // R9
  AST_OE_NEEDS_RDSTB: assert property (@(posedge clk) disable iff (rst)
    host_rdata_oe |-> (!$past(s_ctl.oe_n) || !$past(s_ctl.iord_n))) else $error("data driven without read strobe"); // R9
  AST_INPACK_CFG: assert property (@(posedge clk) disable iff (rst)
    !inpack_n |-> cfg_io_en) else $error("acknowledge while unconfigured"); // R6
  AST_IO_NEEDS_CFG: assert property (@(posedge clk) disable iff (rst)
    ((int_rd || int_wr) && int_space == SPACE_IO) |-> cfg_io_en) else $error("I/O strobe while unconfigured"); // R5

endmodule

// File: tb/pccard_host_decoder_tb_top.sv
module pccard_host_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        card_en_n = 1'b1, reg_sel_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic        iord_n = 1'b1, iowr_n = 1'b1;
  logic [11:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rdata_oe, inpack_n, wait_n, int_rd, int_wr, cfg_io_en;
  logic [1:0]  int_space;
  logic [11:0] int_addr;
  logic [7:0]  int_wdata;
  logic [7:0]  int_rdata = '0;
  logic        int_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pccard_host_decoder dut_i (
    .clk(clk), .rst(rst), .card_en_n(card_en_n), .reg_sel_n(reg_sel_n), .oe_n(oe_n),
    .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .inpack_n(inpack_n), .wait_n(wait_n), .int_rd(int_rd), .int_wr(int_wr),
    .int_space(int_space), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_rdata(int_rdata), .int_ready(int_ready), .cfg_io_en(cfg_io_en)
  );

  typedef struct packed {
    logic        is_rd;
    logic [1:0]  sp;
    logic [11:0] a;
    logic [7:0]  d;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // internal target model
  logic [7:0] mem [0:255];
  int lat = 0;
  int cnt = 0;
  bit busy = 0;
  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    int_ready <= 1'b0;
    if (busy) begin
      if (cnt == 0) begin int_ready <= 1'b1; busy <= 0; end
      else cnt <= cnt - 1;
    end else if (int_rd || int_wr) begin
      if (int_wr) mem[int_addr[7:0]] <= int_wdata;
      int_rdata <= mem[int_addr[7:0]];
      if (lat == 0) int_ready <= 1'b1;
      else begin busy <= 1; cnt <= lat - 1; end
    end
  end

  // monitor: scoreboard of strobes and wait behaviour
  bit ready_prev = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (int_rd || int_wr) begin
        check(!wait_n, "R10", "wait_n with strobe", wait_n, 0);
        if (exp_q.size() == 0) begin
          check(0, "R11", "unexpected strobe addr", int_addr, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int_rd == e.is_rd, "R11", "strobe kind", int_rd, e.is_rd);
          check(int_space == e.sp, "R2", "space code", int_space, e.sp);
          check(int_addr == e.a, "R4", "byte address", int_addr, e.a);
          if (!e.is_rd) check(int_wdata == e.d, "R2", "write data", int_wdata, e.d);
        end
      end
      if (int_ready) check(!wait_n, "R10", "wait_n before ready seen", wait_n, 0);
      if (ready_prev) check(wait_n, "R10", "wait_n one clock after ready", wait_n, 1);
    end
    ready_prev = int_ready && !rst;
  end

  task automatic go_idle();
    @(negedge clk);
    card_en_n = 1; reg_sel_n = 1; oe_n = 1; we_n = 1; iord_n = 1; iowr_n = 1;
  endtask

  // one host access; fwd: expect internal strobe; resp: expect a read answer
  task automatic access(input bit regn, input bit io, input bit rd, input logic [11:0] a,
                        input logic [7:0] wd, input bit fwd, input bit resp,
                        input logic [7:0] exp_rd, input string req);
    if (fwd) exp_q.push_back({rd, io ? 2'b10 : (regn ? 2'b00 : 2'b01), a, wd});
    @(negedge clk);
    card_en_n = 0; reg_sel_n = regn; host_addr = a; host_wdata = wd;
    if (io) begin iord_n = !rd; iowr_n = rd; end
    else    begin oe_n = !rd; we_n = rd; end
    repeat (2) @(negedge clk);
    for (int n = 0; n < 60 && !wait_n; n++) @(negedge clk);
    @(negedge clk);
    check(wait_n, req, "wait_n released", wait_n, 1);
    if (rd) begin
      check(host_rdata_oe == resp, req, "rdata_oe during read", host_rdata_oe, resp);
      if (resp) check(host_rdata == exp_rd, req, "read data", host_rdata, exp_rd);
      if (io) check(inpack_n == !resp, "R6", "inpack_n during I/O read", inpack_n, !resp);
    end
    go_idle();
    repeat (2) @(negedge clk);
    check(!host_rdata_oe, "R9", "rdata_oe after strobe release", host_rdata_oe, 0);
    check(inpack_n, "R6", "inpack_n after release", inpack_n, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic raw(input bit ce, input bit regn, input bit oe, input bit we,
                     input bit ird, input bit iwr, input logic [11:0] a, input string req);
    @(negedge clk);
    card_en_n = ce; reg_sel_n = regn; oe_n = oe; we_n = we; iord_n = ird; iowr_n = iwr;
    host_addr = a;
    repeat (4) @(negedge clk);
    check(!host_rdata_oe, req, "no drive", host_rdata_oe, 0);
    check(inpack_n, req, "no acknowledge", inpack_n, 1);
    check(wait_n, req, "no wait", wait_n, 1);
    go_idle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R7: reset state
    check(wait_n && inpack_n && !host_rdata_oe && !int_rd && !int_wr, "R7", "reset outputs",
          {wait_n, inpack_n, host_rdata_oe}, 3'b110);
    check(!cfg_io_en, "R7", "cfg_io_en at reset", cfg_io_en, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    access(0, 0, 1, 12'h200, 8'h00, 0, 1, 8'h00, "R7");       // option byte reads zero
    // R2, R4: common memory even/odd
    access(1, 0, 0, 12'h010, 8'hA5, 1, 0, 8'h00, "R2");
    access(1, 0, 0, 12'h011, 8'h5A, 1, 0, 8'h00, "R4");
    access(1, 0, 1, 12'h010, 8'h00, 1, 1, 8'hA5, "R2");
    access(1, 0, 1, 12'h011, 8'h00, 1, 1, 8'h5A, "R4");
    // R3: attribute memory
    access(0, 0, 0, 12'h020, 8'h3C, 1, 0, 8'h00, "R3");
    access(0, 0, 1, 12'h020, 8'h00, 1, 1, 8'h3C, "R3");
    // R5, R6: I/O ignored while unconfigured
    access(0, 1, 1, 12'h003, 8'h00, 0, 0, 8'h00, "R5");
    access(0, 1, 0, 12'h004, 8'h77, 0, 0, 8'h00, "R5");
    // R8: option byte with zero index keeps memory-only mode
    access(0, 0, 0, 12'h200, 8'hC0, 0, 0, 8'h00, "R8");
    check(!cfg_io_en, "R8", "zero index leaves unconfigured", cfg_io_en, 0);
    access(0, 0, 0, 12'h200, 8'h41, 0, 0, 8'h00, "R8");
    check(cfg_io_en, "R8", "nonzero index configures", cfg_io_en, 1);
    access(0, 0, 1, 12'h200, 8'h00, 0, 1, 8'h41, "R8");
    // R5, R6: I/O after configuration; earlier ignored write left memory at zero
    access(0, 1, 1, 12'h004, 8'h00, 1, 1, 8'h00, "R5");
    access(0, 1, 0, 12'h004, 8'h99, 1, 0, 8'h00, "R5");
    access(0, 1, 1, 12'h004, 8'h00, 1, 1, 8'h99, "R6");
    access(0, 1, 1, 12'h035, 8'h00, 0, 0, 8'h00, "R5");        // outside I/O window
    // R1: standby; invalid strobe combination
    raw(1, 1, 0, 1, 1, 1, 12'h010, "R1");
    raw(1, 0, 1, 1, 0, 1, 12'h004, "R1");
    raw(0, 1, 0, 0, 1, 1, 12'h010, "R2");
    // R10: long target latency
    lat = 6;
    access(1, 0, 1, 12'h010, 8'h00, 1, 1, 8'hA5, "R10");
    access(1, 0, 0, 12'h012, 8'h6E, 1, 0, 8'h00, "R10");
    lat = 0;
    // R7: reset returns to memory-only
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    repeat (2) @(negedge clk);
    check(!cfg_io_en, "R7", "unconfigured after reset", cfg_io_en, 0);
    access(0, 0, 1, 12'h200, 8'h00, 0, 1, 8'h00, "R7");
    access(0, 1, 1, 12'h004, 8'h00, 0, 0, 8'h00, "R7");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11", "all expected strobes seen", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule